// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is the per-core counting unit of a performance monitor. It holds four general counters, 48 bits wide. Every cycle it takes a small occurrence count for each of several events from an event bus, together with the current privilege level. Each counter has a control register. The control register picks one event and sets a chain of filters: privilege qualification, a threshold compare, inversion and edge detection. The filter chain decides how much the counter advances in that cycle.

Software programs the unit through a flat register interface. Writes take effect on the clock edge and reads are combinational. A global enable register switches each counter on or off. A sticky overflow register records counters that wrapped. A sticky error register records rejected control writes.

Each counter's edge detector is a two-state machine. `HIST_LOW` means the qualified condition was false in the previous counted cycle, and `HIST_HIGH` means it was true. The machine follows the qualified condition (`LOW->HIGH` on true, `HIGH->LOW` on false). It is forced back to `HIST_LOW` while the counter is disabled, and in the cycle its control register is written. In edge mode, an increment is issued only from `HIST_LOW`.

Top module: `pmc_core_counters`

## Requirements
- R1: Address map: counter i is at address i, the control register of counter i is at 4+i, the enable register is at 8, the overflow status is at 9 and the error status is at 10. Control layout: bits 7:0 threshold, bit 8 user enable, bit 9 kernel enable, bit 10 invert, bit 11 edge, bits 15:12 event select. After reset every register reads zero.
- R2: Privilege level 0 allows counting only if the kernel enable is set. Levels 1, 2 and 3 allow counting only if the user enable is set. In a cycle that is not allowed, the counter does not advance.
- R3: With threshold 0, invert clear and edge clear, the counter adds the selected event's occurrence count each cycle.
- R4: With a nonzero threshold, the counter adds one in each cycle where the occurrence count is greater than or equal to the threshold, and zero otherwise.
- R5: With invert set, the counter adds one in cycles where the compare fails. With threshold 0 and invert set, the compare is "count >= 1", so cycles with zero occurrences are counted.
- R6: With edge set, the counter adds one only in a cycle where the qualified condition is true and it was false in the previous counted cycle.
- R7: A control write that sets edge with threshold 0 is rejected: the control register keeps its old value and the error bit for that counter sets. Writing 1 to an error bit clears it.
- R8: Counters wrap from 2^48-1 to the low bits of the sum. A wrap sets that counter's sticky overflow bit. Writing 1 to an overflow bit clears it.
- R9: A counter whose enable bit is 0 holds its value, and its edge history returns to `HIST_LOW`.
- R10: A software write to a counter wins over an increment in the same cycle.
- R11: The event select field picks which event lane feeds the counter. Lane e occupies bits 4e+3:4e of the event bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_occ | input | 32 | Per-cycle occurrence counts, 4 bits per event lane, 8 lanes |
| priv_lvl | input | 2 | Current privilege level (0 is kernel) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 48 | Register write data |
| reg_rdata | output | 48 | Register read data, combinational on reg_addr |

## Verification
The assertions assume that the event bus and privilege level are steady around each rising edge. They also assume that a control register changes only through a write strobe, in the same cycle that clears its edge history. The edge check further assumes that a counter's configuration does not change between two consecutive cycles unless such a write occurs. The stimulus drives all inputs on the falling edge and changes configuration only through the register port, so it stays within these assumptions. Unselected event lanes carry the maximum count, so a wrong lane selection shows up as a large count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int THR_W = 8;
    localparam int SEL_W = 4;

    typedef struct packed {
        logic [SEL_W-1:0] evsel;
        logic             edge_en;
        logic             invert;
        logic             kern_en;
        logic             user_en;
        logic [THR_W-1:0] thresh;
    } pmc_ctl_t;

    localparam int CTL_W = $bits(pmc_ctl_t);

    typedef enum logic {
        HIST_LOW  = 1'b0,
        HIST_HIGH = 1'b1
    } hist_state_e;

endpackage

// File: rtl/pmc_event_filter.sv
module pmc_event_filter
    import pmc_pkg::*;
#(
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             hist_clr,
    input  pmc_ctl_t         ctl,
    input  logic [OCC_W-1:0] occ,
    input  logic [1:0]       priv,
    output logic [OCC_W-1:0] inc
);

    localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;

    hist_state_e      state_q, state_d;
    logic             priv_ok, raw_mode, cond, qual, pulse;
    logic [THR_W-1:0] thr_eff;

    // filter chain: privilege -> compare -> invert
    always_comb begin
        priv_ok  = (priv == 2'd0) ? ctl.kern_en : ctl.user_en;
        raw_mode = (ctl.thresh == '0) && !ctl.invert && !ctl.edge_en;
        thr_eff  = (ctl.thresh == '0) ? THR_W'(1) : ctl.thresh;
        cond     = CMP_W'(occ) >= CMP_W'(thr_eff);
        qual     = (cond ^ ctl.invert) && priv_ok;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HIST_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cnt_en || hist_clr) begin
            state_d = HIST_LOW;
        end else begin
            unique case (state_q)
                HIST_LOW:  state_d = qual ? HIST_HIGH : HIST_LOW;
                HIST_HIGH: state_d = qual ? HIST_HIGH : HIST_LOW;
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            HIST_LOW:  pulse = qual;
            HIST_HIGH: pulse = qual && !ctl.edge_en;
        endcase
        if (!priv_ok)      inc = '0;
        else if (raw_mode) inc = occ;
        else               inc = OCC_W'(pulse);
    end

    // R2: a level that is not enabled never yields an increment
    a_r2_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv == 2'd0 && !ctl.kern_en) || (priv != 2'd0 && !ctl.user_en)) |-> inc == '0);

    // R6: in edge mode an increment is never followed by another one
    a_r6_edge_once: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !hist_clr && ctl.edge_en && inc != '0) |=> inc == '0);

endmodule

// File: rtl/pmc_count_reg.sv
module pmc_count_reg #(
    parameter int CNT_W = 48,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [OCC_W-1:0] inc,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W:0] sum;

    always_comb sum = {1'b0, cnt} + (CNT_W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (sw_wr)       cnt <= sw_data;
            else if (cnt_en) cnt <= sum[CNT_W-1:0];
            if (!sw_wr && cnt_en && sum[CNT_W]) ovf <= 1'b1;
            else if (ovf_clr)                   ovf <= 1'b0;
        end
    end

    // R10: software write wins over a concurrent increment
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_wr) |-> cnt == $past(sw_data));

    // R9: a disabled counter keeps its value
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !$past(sw_wr)) |-> cnt == $past(cnt));

    // R8: a counter that moved backwards without a write has flagged overflow
    a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sw_wr) && cnt < $past(cnt)) |-> ovf);

endmodule

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs
    import pmc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CTL_W-1:0]   wdata,
    output pmc_ctl_t           ctl [NUM_CNT],
    output logic [NUM_CNT-1:0] cnt_en,
    output logic [NUM_CNT-1:0] cfg_err,
    output logic [NUM_CNT-1:0] cnt_wr,
    output logic [NUM_CNT-1:0] ctl_wr,
    output logic [NUM_CNT-1:0] ovf_clr
);

    localparam int A_CTL0 = NUM_CNT;
    localparam int A_EN   = 2 * NUM_CNT;
    localparam int A_OVF  = A_EN + 1;
    localparam int A_ERR  = A_EN + 2;

    pmc_ctl_t wr_ctl;
    logic     wr_bad;

    always_comb begin
        wr_ctl = pmc_ctl_t'(wdata);
        wr_bad = wr_ctl.edge_en && (wr_ctl.thresh == '0);
        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_wr[i] = wr && (addr == ADDR_W'(i));
            ctl_wr[i] = wr && (addr == ADDR_W'(A_CTL0 + i));
        end
        ovf_clr = (wr && addr == ADDR_W'(A_OVF)) ? wdata[NUM_CNT-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CNT; i++) ctl[i] <= '0;
            cnt_en  <= '0;
            cfg_err <= '0;
        end else begin
            if (wr && addr == ADDR_W'(A_EN))  cnt_en  <= wdata[NUM_CNT-1:0];
            if (wr && addr == ADDR_W'(A_ERR)) cfg_err <= cfg_err & ~wdata[NUM_CNT-1:0];
            for (int i = 0; i < NUM_CNT; i++) begin
                if (ctl_wr[i]) begin
                    if (wr_bad) cfg_err[i] <= 1'b1;
                    else        ctl[i]     <= wr_ctl;
                end
            end
        end
    end

    // R7: an edge-with-zero-threshold write leaves the register and flags it
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        a_r7_reject: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr[g] && wr_bad) |=> (ctl[g] == $past(ctl[g])) && cfg_err[g]);
    end

endmodule

// File: rtl/pmc_core_counters.sv
module pmc_core_counters
    import pmc_pkg::*;
#(
    parameter int NUM_CNT    = 4,
    parameter int NUM_EVENTS = 8,
    parameter int OCC_W      = 4,
    parameter int CNT_W      = 48,
    parameter int ADDR_W     = $clog2(2 * NUM_CNT + 3)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_EVENTS*OCC_W-1:0] evt_occ,
    input  logic [1:0]                  priv_lvl,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [CNT_W-1:0]            reg_wdata,
    output logic [CNT_W-1:0]            reg_rdata
);

    localparam int A_CTL0 = NUM_CNT;
    localparam int A_EN   = 2 * NUM_CNT;
    localparam int A_OVF  = A_EN + 1;
    localparam int A_ERR  = A_EN + 2;

    pmc_ctl_t           ctl [NUM_CNT];
    logic [NUM_CNT-1:0] cnt_en, cfg_err, cnt_wr, ctl_wr, ovf_clr, ovf;
    logic [CNT_W-1:0]   cnt [NUM_CNT];

    pmc_ctrl_regs #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata[CTL_W-1:0]),
        .ctl     (ctl),
        .cnt_en  (cnt_en),
        .cfg_err (cfg_err),
        .cnt_wr  (cnt_wr),
        .ctl_wr  (ctl_wr),
        .ovf_clr (ovf_clr)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [OCC_W-1:0] occ_sel;
        logic [OCC_W-1:0] inc;

        // event lane selection, out-of-range select reads as zero
        always_comb begin
            occ_sel = '0;
            for (int e = 0; e < NUM_EVENTS; e++) begin
                if (ctl[g].evsel == SEL_W'(e)) occ_sel = evt_occ[e*OCC_W +: OCC_W];
            end
        end

        pmc_event_filter #(.OCC_W(OCC_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en   (cnt_en[g]),
            .hist_clr (ctl_wr[g]),
            .ctl      (ctl[g]),
            .occ      (occ_sel),
            .priv     (priv_lvl),
            .inc      (inc)
        );

        pmc_count_reg #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (cnt_en[g]),
            .inc     (inc),
            .sw_wr   (cnt_wr[g]),
            .sw_data (reg_wdata),
            .ovf_clr (ovf_clr[g]),
            .cnt     (cnt[g]),
            .ovf     (ovf[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(i))          reg_rdata = cnt[i];
            if (reg_addr == ADDR_W'(A_CTL0 + i)) reg_rdata = CNT_W'(ctl[i]);
        end
        if (reg_addr == ADDR_W'(A_EN))  reg_rdata = CNT_W'(cnt_en);
        if (reg_addr == ADDR_W'(A_OVF)) reg_rdata = CNT_W'(ovf);
        if (reg_addr == ADDR_W'(A_ERR)) reg_rdata = CNT_W'(cfg_err);
    end

endmodule

// File: tb/pmc_core_counters_test.sv
module pmc_core_counters_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_occ = '0;
    logic [1:0]  priv_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [47:0] reg_wdata = '0;
    logic [47:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pmc_core_counters uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_occ   (evt_occ),
        .priv_lvl  (priv_lvl),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {req, evsel, thr, user, kern, inv, occ, priv, expected, pad}
    localparam logic [31:0] VEC [0:11] = '{
        {4'd3,  4'd0, 8'd0,   1'b1, 1'b0, 1'b0, 4'd5,  2'd3, 4'd5, 3'd0}, // R3 raw add
        {4'd2,  4'd0, 8'd0,   1'b0, 1'b1, 1'b0, 4'd5,  2'd3, 4'd0, 3'd0}, // R2 user level, kernel only
        {4'd2,  4'd0, 8'd0,   1'b0, 1'b1, 1'b0, 4'd7,  2'd0, 4'd7, 3'd0}, // R2 kernel level counts
        {4'd2,  4'd0, 8'd0,   1'b1, 1'b0, 1'b0, 4'd7,  2'd0, 4'd0, 3'd0}, // R2 kernel level, user only
        {4'd4,  4'd0, 8'd3,   1'b1, 1'b0, 1'b0, 4'd3,  2'd1, 4'd1, 3'd0}, // R4 equal meets
        {4'd4,  4'd0, 8'd3,   1'b1, 1'b0, 1'b0, 4'd2,  2'd1, 4'd0, 3'd0}, // R4 below
        {4'd5,  4'd0, 8'd3,   1'b1, 1'b0, 1'b1, 4'd2,  2'd2, 4'd1, 3'd0}, // R5 inverted below
        {4'd5,  4'd0, 8'd3,   1'b1, 1'b0, 1'b1, 4'd9,  2'd2, 4'd0, 3'd0}, // R5 inverted above
        {4'd5,  4'd0, 8'd0,   1'b1, 1'b0, 1'b1, 4'd0,  2'd3, 4'd1, 3'd0}, // R5 zero-occurrence cycle
        {4'd11, 4'd5, 8'd0,   1'b1, 1'b0, 1'b0, 4'd4,  2'd3, 4'd4, 3'd0}, // R11 lane 5
        {4'd4,  4'd2, 8'd200, 1'b1, 1'b0, 1'b0, 4'd15, 2'd3, 4'd0, 3'd0}, // R4 threshold out of reach
        {4'd2,  4'd0, 8'd3,   1'b0, 1'b1, 1'b1, 4'd2,  2'd2, 4'd0, 3'd0}  // R2 gate after invert
    };

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [47:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [47:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic step(input logic [3:0] occ0);
        @(negedge clk);
        evt_occ[3:0] = occ0;
        @(posedge clk);
    endtask

    function automatic logic [47:0] mk_ctl(input logic [3:0] sel, input logic edg, input logic inv,
                                           input logic kern, input logic user, input logic [7:0] thr);
        return 48'({sel, edg, inv, kern, user, thr});
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [47:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), d);
            chk($sformatf("R1 reset addr %0d", a), d, 48'd0);
        end

        // table walk on counter 0
        for (int i = 0; i < 12; i++) begin
            logic [31:0] v;
            v = VEC[i];
            @(negedge clk);
            evt_occ = '1;
            evt_occ[v[27:24]*4 +: 4] = v[12:9];
            priv_lvl = v[8:7];
            wr(4'd4, mk_ctl(v[27:24], 1'b0, v[13], v[14], v[15], v[23:16]));
            wr(4'd0, 48'd0);
            wr(4'd8, 48'h1);
            wr(4'd8, 48'h0);
            rd(4'd0, d);
            chk($sformatf("R%0d vector %0d", v[31:28], i), d, 48'(v[6:3]));
        end

        // R6 edge detect, threshold 2, user level
        @(negedge clk);
        evt_occ = '0; priv_lvl = 2'd3;
        wr(4'd4, mk_ctl(4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2));
        wr(4'd0, 48'd0);
        wr(4'd8, 48'h1);
        step(4'd3); step(4'd3); step(4'd0); step(4'd3);
        wr(4'd8, 48'h0);
        rd(4'd0, d);
        chk("R6 two rising transitions", d, 48'd2);

        // R9 history cleared while disabled: condition still true, counts again
        wr(4'd8, 48'h1);
        wr(4'd8, 48'h0);
        rd(4'd0, d);
        chk("R9 edge history cleared by disable", d, 48'd3);

        // R9 disabled counter holds
        wr(4'd5, mk_ctl(4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0));
        wr(4'd1, 48'd77);
        step(4'd9); step(4'd9); step(4'd9);
        rd(4'd1, d);
        chk("R9 disabled counter holds", d, 48'd77);

        // R8 wrap and sticky overflow
        @(negedge clk);
        evt_occ = '0; evt_occ[3:0] = 4'd2;
        wr(4'd4, mk_ctl(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0));
        wr(4'd0, 48'hFFFF_FFFF_FFFF);
        wr(4'd8, 48'h1);
        wr(4'd8, 48'h0);
        rd(4'd0, d);
        chk("R8 wrapped value", d, 48'd1);
        rd(4'd9, d);
        chk("R8 overflow bit set", d, 48'h1);
        wr(4'd9, 48'h1);
        rd(4'd9, d);
        chk("R8 overflow cleared", d, 48'h0);

        // R10 write wins while counting raw 5 per cycle
        @(negedge clk);
        evt_occ[3:0] = 4'd5;
        wr(4'd0, 48'd0);
        wr(4'd8, 48'h1);
        wr(4'd0, 48'd100);
        rd(4'd0, d);
        chk("R10 write over increment", d, 48'd100);
        wr(4'd8, 48'h0);
        rd(4'd0, d);
        chk("R10 counting resumes after write", d, 48'd105);

        // R7 rejected edge write with zero threshold
        wr(4'd4, mk_ctl(4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd0));
        rd(4'd4, d);
        chk("R7 control unchanged", d, mk_ctl(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0));
        rd(4'd10, d);
        chk("R7 error flagged", d, 48'h1);
        wr(4'd10, 48'h1);
        rd(4'd10, d);
        chk("R7 error cleared", d, 48'h0);

        finish_run();
    end

endmodule